// File: doc/BRIEF.md
# Multi-Source Session Arbiter

This block decides which one of several host ports currently controls an instrument. Each port can ask to open a session, ask to close it, and strobe an activity line whenever it sends a command. The arbiter keeps the owning port in a one-hot register. It answers each open request in one of two ways: it grants the session with a one-cycle pulse, or it refuses the request with a one-cycle busy pulse.

Inactivity is measured in ticks of an external slow strobe, nominally 1 Hz. The owner's own activity restarts the measurement. A port that opened a session and then went silent for the configured number of ticks no longer blocks the others. The next open request from another port takes the session, and the old owner is dropped without any notice. Hosts are expected to detect a lost session, including one lost to an instrument reset, through their own timeouts.

Top module: `session_arbiter`

## Requirements
- R1: After a synchronous reset no port owns the session, and the grant and busy outputs are all zero.
- R2: Bit i of every port-indexed vector belongs to port i. When the session is free and several ports request in the same cycle, the lowest-numbered port becomes owner and receives a grant pulse one cycle long.
- R3: While the owner is not idle, an open request from any other port leaves the owner unchanged and produces a busy pulse one cycle long to that port only.
- R4: The idle count advances by one on each tick while a session is held and saturates at IDLE_TICKS. The owner's activity strobe returns it to zero. Activity strobes from other ports do not change it.
- R5: Once the idle count has reached IDLE_TICKS, the next open request from another port takes the session. The lowest-numbered such port wins, the others get busy, and the old owner gets no grant.
- R6: An activity strobe from the owner in the same cycle as a competing request keeps the session with the owner, even if the owner was idle.
- R7: A close request from the owner frees the session at the next edge, and an open request from another port in that same cycle is granted. A close request from a port that does not own the session has no effect.
- R8: An open request from the current owner produces no grant, no busy pulse and no change of owner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Slow time-base strobe, one cycle per second |
| open_i | input | N_SRC | Open-session request per port |
| close_i | input | N_SRC | Close-session request per port |
| act_i | input | N_SRC | Command-activity strobe per port |
| owner_o | output | N_SRC | One-hot owner of the session, all zero when free |
| grant_o | output | N_SRC | One-cycle pulse to the port that has just won |
| busy_o | output | N_SRC | One-cycle pulse to each refused port |

## Verification
A corrupted owner register shows at once on owner_o, in the cycle after the fault. It also shows as a grant or busy pulse that is wrong on the next open request. An idle count that is wrong only shows at the ports when a competing request arrives. A count that runs ahead grants a takeover that should have been refused with busy. A count that is late refuses a takeover that should have been granted. For this reason the stimulus puts competing requests at the tick just before the threshold and at the tick that reaches it.

// File: rtl/sarb_pkg.sv
package sarb_pkg;
  localparam int unsigned SARB_MAX_SRC = 32;

  function automatic int unsigned sarb_cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/sarb_low_pick.sv
module sarb_low_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] pick_o
);
  for (genvar i = 0; i < N; i++) begin : g_pick
    if (i == 0) begin : g_first
      assign pick_o[i] = req_i[i];
    end else begin : g_rest
      assign pick_o[i] = req_i[i] & ~(|req_i[i-1:0]);
    end
  end
endmodule

// File: rtl/sarb_idle_timer.sv
module sarb_idle_timer
  import sarb_pkg::*;
#(
  parameter int unsigned IDLE_TICKS = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic tick_i,
  output logic idle_o
);
  localparam int unsigned CW = sarb_cnt_width(IDLE_TICKS);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) cnt_q <= '0;
    else if (tick_i && cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign idle_o = (cnt_q == LIMIT);

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT); // R4
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> cnt_q == '0); // R4
endmodule

// File: rtl/session_arbiter.sv
module session_arbiter
  import sarb_pkg::*;
#(
  parameter int unsigned N_SRC      = 4,
  parameter int unsigned IDLE_TICKS = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [N_SRC-1:0] open_i,
  input  logic [N_SRC-1:0] close_i,
  input  logic [N_SRC-1:0] act_i,
  output logic [N_SRC-1:0] owner_o,
  output logic [N_SRC-1:0] grant_o,
  output logic [N_SRC-1:0] busy_o
);
  logic [N_SRC-1:0] owner_q, grant_q, busy_q;
  logic [N_SRC-1:0] owner_d, grant_d, busy_d;
  logic [N_SRC-1:0] cand, pick;
  logic owner_hit, owner_close, idle, held, free, restart;

  assign held        = |owner_q;
  assign owner_hit   = |(act_i & owner_q);
  assign owner_close = |(close_i & owner_q);
  assign cand        = open_i & ~owner_q;
  assign free        = !held || owner_close || (idle && !owner_hit);

  sarb_low_pick #(.N(N_SRC)) pick_i (
    .req_i  (cand),
    .pick_o (pick)
  );

  always_comb begin
    owner_d = owner_q;
    grant_d = '0;
    busy_d  = '0;
    if (free && |cand) begin
      owner_d = pick;
      grant_d = pick;
      busy_d  = cand & ~pick;
    end else if (free) begin
      if (owner_close) owner_d = '0;
    end else begin
      busy_d = cand;
    end
  end

  assign restart = (|grant_d) || owner_hit || !held;

  sarb_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .clear_i (restart),
    .tick_i  (tick_i),
    .idle_o  (idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= '0;
      grant_q <= '0;
      busy_q  <= '0;
    end else begin
      owner_q <= owner_d;
      grant_q <= grant_d;
      busy_q  <= busy_d;
    end
  end

  assign owner_o = owner_q;
  assign grant_o = grant_q;
  assign busy_o  = busy_q;

  AST_OWNER_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(owner_q)); // R2
  AST_GRANT_IS_OWNER: assert property (@(posedge clk) disable iff (rst)
    (grant_q != '0) |-> (grant_q == owner_q)); // R2
  AST_BUSY_NOT_OWNER: assert property (@(posedge clk) disable iff (rst)
    (busy_q & owner_q) == '0); // R3
  AST_HOLD_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (held && !free) |=> (owner_q == $past(owner_q))); // R3
  AST_OWN_OPEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (held && !free && open_i == owner_q) |=> (grant_q == '0 && busy_q == '0)); // R8
  AST_CLOSE_FREES: assert property (@(posedge clk) disable iff (rst)
    (owner_close && cand == '0) |=> (owner_q == '0)); // R7
endmodule

// File: tb/session_arbiter_tb.sv
module session_arbiter_tb_top;
  localparam int N = 4;
  localparam int LIM = 3;
  localparam int NV = 20;

  logic clk = 0, rst = 1, tick = 0;
  logic [N-1:0] open_r = 0, close_r = 0, act_r = 0;
  logic [N-1:0] owner, grant, busy;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  session_arbiter #(.N_SRC(N), .IDLE_TICKS(LIM)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .open_i(open_r), .close_i(close_r),
    .act_i(act_r), .owner_o(owner), .grant_o(grant), .busy_o(busy));

  // open close act tick | owner busy grant | requirement
  localparam logic [28:0] VEC [NV] = '{
    {4'b0000,4'b0000,4'b0000,1'b0, 4'b0000,4'b0000,4'b0000, 4'd1}, // R1 idle after reset
    {4'b0101,4'b0000,4'b0000,1'b0, 4'b0001,4'b0100,4'b0001, 4'd2}, // R2 lowest wins
    {4'b0010,4'b0000,4'b0000,1'b0, 4'b0001,4'b0010,4'b0000, 4'd3}, // R3 refused
    {4'b0000,4'b0000,4'b0000,1'b1, 4'b0001,4'b0000,4'b0000, 4'd4}, // R4 cnt 1
    {4'b0000,4'b0000,4'b0000,1'b1, 4'b0001,4'b0000,4'b0000, 4'd4}, // R4 cnt 2
    {4'b0000,4'b0000,4'b0001,1'b0, 4'b0001,4'b0000,4'b0000, 4'd4}, // R4 owner act -> 0
    {4'b0000,4'b0000,4'b0000,1'b1, 4'b0001,4'b0000,4'b0000, 4'd4}, // R4 cnt 1
    {4'b0000,4'b0000,4'b0010,1'b1, 4'b0001,4'b0000,4'b0000, 4'd4}, // R4 foreign act, cnt 2
    {4'b0100,4'b0000,4'b0000,1'b0, 4'b0001,4'b0100,4'b0000, 4'd3}, // R3 one short of limit
    {4'b0000,4'b0000,4'b0000,1'b1, 4'b0001,4'b0000,4'b0000, 4'd5}, // R5 reaches limit
    {4'b0100,4'b0000,4'b0001,1'b0, 4'b0001,4'b0100,4'b0000, 4'd6}, // R6 owner act saves
    {4'b0000,4'b0000,4'b0000,1'b1, 4'b0001,4'b0000,4'b0000, 4'd4},
    {4'b0000,4'b0000,4'b0000,1'b1, 4'b0001,4'b0000,4'b0000, 4'd4},
    {4'b0000,4'b0000,4'b0000,1'b1, 4'b0001,4'b0000,4'b0000, 4'd4},
    {4'b1010,4'b0000,4'b0000,1'b0, 4'b0010,4'b1000,4'b0010, 4'd5}, // R5 takeover
    {4'b0000,4'b0001,4'b0000,1'b0, 4'b0010,4'b0000,4'b0000, 4'd7}, // R7 foreign close
    {4'b0000,4'b0010,4'b0000,1'b0, 4'b0000,4'b0000,4'b0000, 4'd7}, // R7 owner close
    {4'b1000,4'b0000,4'b0000,1'b0, 4'b1000,4'b0000,4'b1000, 4'd2}, // R2 free open
    {4'b0100,4'b1000,4'b0000,1'b0, 4'b0100,4'b0000,4'b0100, 4'd7}, // R7 close + open
    {4'b0100,4'b0000,4'b0000,1'b0, 4'b0100,4'b0000,4'b0000, 4'd8}  // R8 own open
  };

  task automatic check(input string tag, input logic [N-1:0] eo, eb, eg);
    checks++;
    if (owner !== eo || busy !== eb || grant !== eg) begin
      errors++;
      $display("FAIL %s: owner/busy/grant got %b/%b/%b expected %b/%b/%b",
               tag, owner, busy, grant, eo, eb, eg);
    end
  endtask

  task automatic step(input logic [N-1:0] o, c, a, input logic t);
    @(negedge clk);
    open_r = o; close_r = c; act_r = a; tick = t;
    @(posedge clk); #1;
    open_r = 0; close_r = 0; act_r = 0; tick = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check("R1 reset", 4'b0000, 4'b0000, 4'b0000);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][28:25], VEC[i][24:21], VEC[i][20:17], VEC[i][16]);
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i),
            VEC[i][15:12], VEC[i][11:8], VEC[i][7:4]);
    end
    // R4 saturation: many ticks, then takeover still works once
    for (int k = 0; k < 7; k++) step(0, 0, 0, 1);
    step(4'b0011, 0, 0, 0);
    check("R4 saturated takeover", 4'b0001, 4'b0010, 4'b0001);
    // R5 takeover exactly at limit after fresh grant
    for (int k = 0; k < LIM; k++) step(0, 0, 0, 1);
    step(4'b1000, 0, 0, 0);
    check("R5 takeover at limit", 4'b1000, 4'b0000, 4'b1000);
    // R1 reset mid-session drops owner silently
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    check("R1 reset mid-session", 4'b0000, 4'b0000, 4'b0000);
    @(negedge clk); rst = 0;
    step(4'b0100, 0, 0, 0);
    check("R2 open after reset", 4'b0100, 4'b0000, 4'b0100);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule